// File: doc/BRIEF.md
# Branch Record Stack with Interrupt Freeze

This block keeps a circular history of taken branches. Each entry is a pair: the source address and the destination address. A top-of-stack pointer marks the newest entry. Whenever recording is enabled and the block is not frozen, each retire strobe for a taken branch advances the pointer by one, modulo the depth. The new source/destination pair is then written at the slot the pointer now indicates. A combinational read port returns the pair at any index, and the pointer itself is always visible.

The purpose of the block is to stop the history at the moment a performance-monitor interrupt arrives, so that interrupt-handler code can inspect the history without overwriting it. The freeze is armed only when both the recording enable bit and the freeze-on-interrupt control bit are set. A build parameter selects one of two hand-off protocols:
- **Legacy protocol:** the interrupt clears the enable bit. Software sets the enable bit again to resume recording.
- **Streamlined protocol:** the interrupt raises a freeze flag at bit 58 of a 64-bit status word. Recording is blocked while the flag is up, and software lowers it with a clear pulse.

Top module: `branch_rec_stack`

## Requirements
- R1: After reset the following are all zero: the pointer, every source and destination entry, the enable bit, the freeze-on-interrupt bit and the status word.
- R2: A branch strobe is recorded when the enable bit is 1 and the freeze flag is 0. A recorded strobe advances the pointer by one and wraps from DEPTH-1 to 0. The same edge writes the source and destination at the new pointer position.
- R3: A branch strobe has no effect on the pointer or on any entry while the enable bit is 0.
- R4: An interrupt pulse causes a freeze only if, before the edge, both the enable bit and the freeze-on-interrupt bit are 1. In any other case the pulse changes neither the enable bit nor the status word.
- R5: Legacy protocol:
  - An armed interrupt clears the enable bit at the next edge. This takes priority over a control write in the same cycle.
  - Otherwise the enable bit changes only through a control write, one edge after the write.
  - Recording resumes once the enable bit has been written to 1 again.
- R6: Streamlined protocol:
  - An armed interrupt sets bit 58 of the status word at the next edge. All other status bits stay 0.
  - While bit 58 is set, branch strobes are ignored.
  - The enable bit changes only through control writes.
- R7: Streamlined protocol:
  - A clear pulse lowers bit 58 at the next edge, after which recording resumes.
  - An armed interrupt in the same cycle as a clear pulse wins, and the flag stays set.
- R8: While frozen by either protocol, the pointer and every entry keep their values, even though branch strobes continue to arrive.
- R9: A branch strobe in the same cycle as an armed interrupt is recorded. The freeze applies from the next cycle on.
- R10: The read port returns the stored pair for an index below DEPTH and returns zero for an index at or above DEPTH.
- R11: Legacy protocol: the status word is always zero, and the clear pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Control write strobe |
| ctl_rec_en | input | 1 | Value written to the enable bit |
| ctl_frz_on | input | 1 | Value written to the freeze-on-interrupt bit |
| br_valid | input | 1 | Retire strobe for a taken branch |
| br_src | input | AW | Source address of the branch |
| br_dst | input | AW | Destination address of the branch |
| pmi_pulse | input | 1 | Performance-monitor interrupt pulse |
| frz_clr | input | 1 | Clears the freeze flag (streamlined protocol only) |
| rd_idx | input | IW | Read index, IW = clog2(DEPTH) |
| rd_src | output | AW | Source address stored at rd_idx |
| rd_dst | output | AW | Destination address stored at rd_idx |
| tos | output | IW | Top-of-stack pointer |
| rec_en | output | 1 | Current recording enable bit |
| frz_on_int | output | 1 | Current freeze-on-interrupt bit |
| status | output | 64 | Status word; bit 58 is the freeze flag |

## Verification
Every register result becomes visible after exactly one rising edge of the clock, counted from the cycle in which its inputs were presented. These registered results are the pointer, the stored entries, the enable and freeze-on-interrupt bits, and the freeze flag. The read port has no register stage, so it reflects stored state in the same cycle as the index. The bench presents inputs on the falling edge and updates a behavioural model on the rising edge. It compares on the following falling edge, so each comparison falls exactly one edge after the stimulus. The read index advances by one on every falling edge, which means every slot, including the out-of-range ones, is compared again and again under both protocols.

// File: rtl/brs_pkg.sv
`timescale 1ns/1ps
package brs_pkg;
  localparam int unsigned STAT_W  = 64;
  localparam int unsigned FRZ_BIT = 58;

  // pointer successor, wrapping at depth
  function automatic int unsigned brs_next(input int unsigned cur, input int unsigned depth);
    return (cur + 1 >= depth) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/brs_ptr.sv
`timescale 1ns/1ps
module brs_ptr #(
  parameter int DEPTH = 16,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [IW-1:0] tos_q,
  output logic [IW-1:0] tos_nxt
);
  import brs_pkg::*;

  assign tos_nxt = IW'(brs_next({{(32-IW){1'b0}}, tos_q}, DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tos_q <= '0;
    else if (adv) tos_q <= tos_nxt;
  end
endmodule

// File: rtl/brs_store.sv
`timescale 1ns/1ps
module brs_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 48,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_src,
  input  logic [AW-1:0] wr_dst,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_src,
  output logic [AW-1:0] rd_dst
);
  logic [AW-1:0] src_q [DEPTH];
  logic [AW-1:0] dst_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
      end
    end else if (wr_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_idx == IW'(i)) begin
          src_q[i] <= wr_src;
          dst_q[i] <= wr_dst;
        end
      end
    end
  end

  // indices at or past DEPTH return zero
  always_comb begin
    rd_src = '0;
    rd_dst = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == IW'(i)) begin
        rd_src = src_q[i];
        rd_dst = dst_q[i];
      end
    end
  end
endmodule

// File: rtl/brs_frz_ctl.sv
`timescale 1ns/1ps
module brs_frz_ctl #(
  parameter bit STREAMLINED = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_rec_en,
  input  logic ctl_frz_on,
  input  logic pmi,
  input  logic frz_clr,
  output logic rec_en_q,
  output logic frz_on_q,
  output logic frz_q,
  output logic trig
);
  assign trig = pmi & rec_en_q & frz_on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      frz_on_q <= 1'b0;
    else if (ctl_wr) frz_on_q <= ctl_frz_on;
  end

  generate
    if (STREAMLINED) begin : g_stream
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rec_en_q <= 1'b0;
        else if (ctl_wr) rec_en_q <= ctl_rec_en;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       frz_q <= 1'b0;
        else if (trig)    frz_q <= 1'b1;
        else if (frz_clr) frz_q <= 1'b0;
      end
    end else begin : g_legacy
      logic unused_clr;
      assign unused_clr = frz_clr;
      assign frz_q = 1'b0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rec_en_q <= 1'b0;
        else if (trig)   rec_en_q <= 1'b0;
        else if (ctl_wr) rec_en_q <= ctl_rec_en;
      end
    end
  endgenerate
endmodule

// File: rtl/branch_rec_stack.sv
`timescale 1ns/1ps
module branch_rec_stack #(
  parameter int DEPTH       = 16,
  parameter int AW          = 48,
  parameter bit STREAMLINED = 1'b0,
  localparam int IW         = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          ctl_rec_en,
  input  logic          ctl_frz_on,
  input  logic          br_valid,
  input  logic [AW-1:0] br_src,
  input  logic [AW-1:0] br_dst,
  input  logic          pmi_pulse,
  input  logic          frz_clr,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_src,
  output logic [AW-1:0] rd_dst,
  output logic [IW-1:0] tos,
  output logic          rec_en,
  output logic          frz_on_int,
  output logic [63:0]   status
);
  import brs_pkg::*;

  logic          frz_q;
  logic          record_evt;
  logic          freeze_evt;
  logic [IW-1:0] tos_nxt;

  brs_frz_ctl #(.STREAMLINED(STREAMLINED)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rec_en(ctl_rec_en),
    .ctl_frz_on(ctl_frz_on), .pmi(pmi_pulse), .frz_clr(frz_clr),
    .rec_en_q(rec_en), .frz_on_q(frz_on_int), .frz_q(frz_q), .trig(freeze_evt)
  );

  // a strobe in the trigger cycle still sees pre-edge state
  assign record_evt = br_valid & rec_en & ~frz_q;

  brs_ptr #(.DEPTH(DEPTH), .IW(IW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(record_evt), .tos_q(tos), .tos_nxt(tos_nxt)
  );

  brs_store #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(record_evt), .wr_idx(tos_nxt),
    .wr_src(br_src), .wr_dst(br_dst), .rd_idx(rd_idx),
    .rd_src(rd_src), .rd_dst(rd_dst)
  );

  assign status = {{(STAT_W-FRZ_BIT-1){1'b0}}, frz_q, {FRZ_BIT{1'b0}}};
endmodule

// File: rtl/brs_chk.sv
`timescale 1ns/1ps
module brs_chk #(
  parameter int DEPTH       = 16,
  parameter bit STREAMLINED = 1'b0,
  localparam int IW         = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          br_valid,
  input logic          pmi_pulse,
  input logic          frz_clr,
  input logic          ctl_wr,
  input logic [IW-1:0] tos,
  input logic          rec_en,
  input logic          frz_on_int,
  input logic [63:0]   status,
  input logic          record_evt,
  input logic          freeze_evt
);
  import brs_pkg::*;

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    record_evt |=> tos == IW'(brs_next({{(32-IW){1'b0}}, $past(tos)}, DEPTH)));

  p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && !rec_en |=> $stable(tos));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !record_evt |=> $stable(tos));

  p_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_evt |-> pmi_pulse && rec_en && frz_on_int);

  p_unarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pmi_pulse && !frz_on_int |-> !freeze_evt);

  p_same_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && freeze_evt && !status[FRZ_BIT] |-> record_evt);

  generate
    if (STREAMLINED) begin : g_stream
      p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_evt |=> status[FRZ_BIT]);
      p_only_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~(64'd1 << FRZ_BIT)) == 64'd0);
      p_en_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(rec_en));
      p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status[FRZ_BIT] |=> $stable(tos));
      p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frz_clr && !freeze_evt |=> !status[FRZ_BIT]);
    end else begin : g_legacy
      p_en_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_evt |=> !rec_en);
      p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr && !freeze_evt |=> $stable(rec_en));
      p_clr_inert_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frz_clr |=> status == 64'd0);
    end
  endgenerate
endmodule

bind branch_rec_stack brs_chk #(.DEPTH(DEPTH), .STREAMLINED(STREAMLINED)) u_brs_chk (
  .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .pmi_pulse(pmi_pulse),
  .frz_clr(frz_clr), .ctl_wr(ctl_wr), .tos(tos), .rec_en(rec_en),
  .frz_on_int(frz_on_int), .status(status), .record_evt(record_evt),
  .freeze_evt(freeze_evt)
);

// File: tb/test_branch_rec_stack.sv
`timescale 1ns/1ps
module test_branch_rec_stack;
  localparam int DEPTH = 12;
  localparam int AW    = 32;
  localparam int IW    = $clog2(DEPTH);
  localparam logic [63:0] FLAG = 64'd1 << 58;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          ctl_wr, ctl_rec_en, ctl_frz_on, br_valid, pmi, frz_clr;
  logic [AW-1:0] br_src, br_dst;
  logic [IW-1:0] rd_idx;
  logic [AW-1:0] o_src [2];
  logic [AW-1:0] o_dst [2];
  logic [IW-1:0] o_tos [2];
  logic          o_en  [2];
  logic          o_fon [2];
  logic [63:0]   o_st  [2];

  // index 0: legacy protocol, index 1: streamlined protocol
  branch_rec_stack #(.DEPTH(DEPTH), .AW(AW), .STREAMLINED(1'b0)) i_branch_rec_stack (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rec_en(ctl_rec_en),
    .ctl_frz_on(ctl_frz_on), .br_valid(br_valid), .br_src(br_src), .br_dst(br_dst),
    .pmi_pulse(pmi), .frz_clr(frz_clr), .rd_idx(rd_idx), .rd_src(o_src[0]),
    .rd_dst(o_dst[0]), .tos(o_tos[0]), .rec_en(o_en[0]), .frz_on_int(o_fon[0]),
    .status(o_st[0]));

  branch_rec_stack #(.DEPTH(DEPTH), .AW(AW), .STREAMLINED(1'b1)) i_branch_rec_stack_s (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rec_en(ctl_rec_en),
    .ctl_frz_on(ctl_frz_on), .br_valid(br_valid), .br_src(br_src), .br_dst(br_dst),
    .pmi_pulse(pmi), .frz_clr(frz_clr), .rd_idx(rd_idx), .rd_src(o_src[1]),
    .rd_dst(o_dst[1]), .tos(o_tos[1]), .rec_en(o_en[1]), .frz_on_int(o_fon[1]),
    .status(o_st[1]));

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference
  int          m_tos [2];
  bit          m_en  [2];
  bit          m_fon [2];
  bit          m_frz [2];
  logic [AW-1:0] m_src [2][$];
  logic [AW-1:0] m_dst [2][$];

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      m_tos[k] = 0; m_en[k] = 0; m_fon[k] = 0; m_frz[k] = 0;
      m_src[k].delete(); m_dst[k].delete();
      for (int i = 0; i < DEPTH; i++) begin
        m_src[k].push_back('0);
        m_dst[k].push_back('0);
      end
    end
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      for (int k = 0; k < 2; k++) begin
        bit rec, trig;
        rec  = br_valid && m_en[k] && !m_frz[k];
        trig = pmi && m_en[k] && m_fon[k];
        if (rec) begin
          m_tos[k] = (m_tos[k] + 1) % DEPTH;
          m_src[k][m_tos[k]] = br_src;
          m_dst[k][m_tos[k]] = br_dst;
        end
        if (k == 0) begin
          if (trig) m_en[0] = 0;
          else if (ctl_wr) m_en[0] = ctl_rec_en;
        end else begin
          if (ctl_wr) m_en[1] = ctl_rec_en;
          if (trig) m_frz[1] = 1;
          else if (frz_clr) m_frz[1] = 0;
        end
        if (ctl_wr) m_fon[k] = ctl_frz_on;
      end
    end
  end

  // per-cycle comparison on the falling edge; read index walks every slot
  int walk = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int k = 0; k < 2; k++) begin
        chk(o_tos[k] == IW'(m_tos[k]), "R2", "pointer", o_tos[k], m_tos[k]);
        chk(o_en[k] == m_en[k], k ? "R6" : "R5", "enable bit", o_en[k], m_en[k]);
        chk(o_fon[k] == m_fon[k], "R4", "freeze-on-int bit", o_fon[k], m_fon[k]);
        chk(o_st[k] == (m_frz[k] ? FLAG : 64'd0), k ? "R7" : "R11", "status",
            o_st[k], m_frz[k] ? FLAG : 64'd0);
        if (walk < DEPTH) begin
          chk(o_src[k] == m_src[k][walk], "R2", "source entry", o_src[k], m_src[k][walk]);
          chk(o_dst[k] == m_dst[k][walk], "R2", "dest entry", o_dst[k], m_dst[k][walk]);
        end else begin
          chk(o_src[k] == '0, "R10", "source out of range", o_src[k], 0);
          chk(o_dst[k] == '0, "R10", "dest out of range", o_dst[k], 0);
        end
      end
      walk = (walk + 1) % (1 << IW);
      rd_idx = IW'(walk);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected at most 200000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle();
    ctl_wr = 0; ctl_rec_en = 0; ctl_frz_on = 0; br_valid = 0;
    pmi = 0; frz_clr = 0; br_src = '0; br_dst = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic ctl(input bit en, input bit fon);
    ctl_wr = 1; ctl_rec_en = en; ctl_frz_on = fon;
    tick();
  endtask

  task automatic branches(input int n);
    for (int i = 0; i < n; i++) begin
      br_valid = 1; br_src = $urandom; br_dst = $urandom;
      tick();
    end
  endtask

  initial begin
    idle();
    rd_idx = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < 2; k++) begin
      chk(o_tos[k] == 0, "R1", "reset pointer", o_tos[k], 0);
      chk(o_en[k] == 0 && o_fon[k] == 0, "R1", "reset control bits", {o_en[k], o_fon[k]}, 0);
      chk(o_st[k] == 0, "R1", "reset status", o_st[k], 0);
      chk(o_src[k] == 0 && o_dst[k] == 0, "R1", "reset entry 0", o_src[k], 0);
    end

    branches(3);
    for (int k = 0; k < 2; k++) chk(o_tos[k] == 0, "R3", "disabled strobes", o_tos[k], 0);

    ctl(1, 0);
    branches(5);
    for (int k = 0; k < 2; k++) chk(o_tos[k] == 5, "R2", "advance", o_tos[k], 5);

    pmi = 1; tick();
    for (int k = 0; k < 2; k++) begin
      chk(o_en[k] == 1, "R4", "unarmed interrupt keeps enable", o_en[k], 1);
      chk(o_st[k] == 0, "R4", "unarmed interrupt keeps status", o_st[k], 0);
    end

    branches(10);
    for (int k = 0; k < 2; k++) chk(o_tos[k] == 3, "R2", "wrap at depth", o_tos[k], 3);

    ctl(1, 1);
    pmi = 1; br_valid = 1; br_src = 32'hA5A5_0001; br_dst = 32'h5A5A_0002; tick();
    for (int k = 0; k < 2; k++) chk(o_tos[k] == 4, "R9", "strobe in trigger cycle", o_tos[k], 4);
    chk(o_en[0] == 0, "R5", "legacy enable cleared", o_en[0], 0);
    chk(o_st[1] == FLAG, "R6", "streamlined flag set", o_st[1], FLAG);
    chk(o_en[1] == 1, "R6", "streamlined enable kept", o_en[1], 1);

    branches(4);
    for (int k = 0; k < 2; k++) chk(o_tos[k] == 4, "R8", "frozen pointer", o_tos[k], 4);

    frz_clr = 1; tick();
    chk(o_st[0] == 0 && o_en[0] == 0, "R11", "legacy clear inert", o_st[0], 0);
    chk(o_st[1] == 0, "R7", "streamlined flag cleared", o_st[1], 0);

    ctl(1, 1);
    branches(2);
    chk(o_tos[0] == 6, "R5", "legacy resume", o_tos[0], 6);
    chk(o_tos[1] == 6, "R7", "streamlined resume", o_tos[1], 6);

    pmi = 1; frz_clr = 1; tick();
    chk(o_st[1] == FLAG, "R7", "set beats clear", o_st[1], FLAG);
    chk(o_en[0] == 0, "R5", "legacy trigger with clear", o_en[0], 0);

    frz_clr = 1; tick();
    ctl(0, 1);
    pmi = 1; tick();
    for (int k = 0; k < 2; k++) chk(o_st[k] == 0, "R4", "interrupt with enable off", o_st[k], 0);
    ctl(1, 0);
    pmi = 1; tick();
    chk(o_st[1] == 0, "R4", "interrupt with freeze-on-int off", o_st[1], 0);
    chk(o_en[0] == 1, "R4", "legacy enable kept when unarmed", o_en[0], 1);

    for (int n = 0; n < 3000; n++) begin
      br_valid   = ($urandom % 3) != 0;
      br_src     = $urandom;
      br_dst     = $urandom;
      pmi        = ($urandom % 20) == 0;
      frz_clr    = ($urandom % 9) == 0;
      ctl_wr     = ($urandom % 12) == 0;
      ctl_rec_en = ($urandom % 4) != 0;
      ctl_frz_on = ($urandom % 3) != 0;
      tick();
    end

    tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule